// File: doc/BRIEF.md
# Fuse Word Read Controller

This block is a register-mapped controller that fetches 32-bit words from a 128-word one-time-programmable fuse array. Software puts a word address in the control register, loads a timing register with relax and read-strobe counts, and then writes the read command. The controller raises a busy flag while it runs a timed sense sequence of three phases: setup, strobe and hold. At the end it drops busy, captures the fuse word into a read-result register and reports any error in the control register.

The control register can be written directly, or bit by bit through a set alias, which ORs the data in, and a clear alias, which removes the bits given as ones. A failed read does not return fuse data. It returns a fixed poison word and sets the error flag. The fuse contents are modelled inside the block. A test-only load port fills them before use, and reset does not disturb them. The unlock key field and the program-strobe field are stored and read back, but nothing else uses them.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset the control (0x00), timing (0x10) and read-result (0x40) registers read 0 and busy is low. Fuse words loaded before a reset can still be read after it.
- R2: A write to 0x00 stores the word address in bits 6:0, the error flag in bit 9, the reload flag in bit 10 and the unlock key in bits 31:16. Bits 7 and 15:11 always read 0.
- R3: A write to 0x04 ORs the data into the control register. A write to 0x08 clears every control bit that is 1 in the data, so the mask 0x200 clears the error flag.
- R4: The timing register at 0x10 holds the program strobe in bits 11:0, relax in bits 15:12 and read strobe in bits 21:16. Bits 31:22 read 0.
- R5: Writing a word with bit 0 set to 0x30 while idle starts a read at the control address. Busy (control bit 8) is then high for exactly 2*(relax+1)+(read strobe+1) cycles. When busy falls, the read-result register holds the fuse word.
- R6: A read started with a read-strobe field of 0 runs the same sequence length. It finishes with 0xBADABADA in the read-result register and the error flag set.
- R7: A read command issued while busy is ignored, but it sets the error flag. The read in progress keeps its length and its result.
- R8: Busy is read-only. Writing bit 8 through 0x00, 0x04 or 0x08 does not change it.
- R9: While busy, writes to the timing register and to the control address field are ignored. The other control fields still accept writes.
- R10: When a failing read completes in the same cycle as a write that clears the error flag, the error flag ends up set.
- R11: A write to 0x30 with bit 0 clear starts nothing.
- R12: The test load port writes a word into the fuse array at the given word address. A later read returns that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read enable; bus_rdata is 0 when it is low |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| tp_load | input | 1 | Test-only fuse array write enable |
| tp_addr | input | 7 | Test-only fuse word address |
| tp_data | input | 32 | Test-only fuse word |

## Verification
Two events can fall in the same cycle. One is the hardware setting the error flag when a read completes. The other is a software write to the control register through an alias or a second read command. To provoke the first case, the bench starts a zero-strobe read and places a clear-alias write on the exact completion edge. It then checks that the error flag reads back set and that the result is the poison word. The bench also issues a command while busy and writes to timing and address during busy. It then checks cycle by cycle that busy keeps its computed length and that the result comes from the original address.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
    localparam int BUS_W  = 32;
    localparam int RLX_W  = 4;
    localparam int STB_W  = 6;
    localparam int PRG_W  = 12;
    localparam int KEY_W  = 16;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_SET    = 8'h04;
    localparam logic [7:0] OFS_CLR    = 8'h08;
    localparam logic [7:0] OFS_TIMING = 8'h10;
    localparam logic [7:0] OFS_PGM    = 8'h20;
    localparam logic [7:0] OFS_CMD    = 8'h30;
    localparam logic [7:0] OFS_RESULT = 8'h40;

    localparam int BIT_BUSY   = 8;
    localparam int BIT_ERR    = 9;
    localparam int BIT_RELOAD = 10;
    localparam int KEY_LSB    = 16;

    localparam logic [BUS_W-1:0] POISON_WORD = 32'hBADA_BADA;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;
endpackage

// File: rtl/fuse_array.sv
module fuse_array #(
    parameter int WORDS = 128,
    parameter int DW    = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] cells_q [WORDS];

    // no reset: contents survive a controller reset
    always_ff @(posedge clk) begin
        if (load_en) begin
            cells_q[load_addr] <= load_data;
        end
    end

    assign rd_data = cells_q[rd_addr];
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
    import fuse_rd_pkg::*;
#(
    parameter int RW  = 4,
    parameter int SW  = 6,
    localparam int CW = (RW > SW) ? RW : SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW-1:0] relax,
    input  logic [SW-1:0] strobe,
    output logic          busy,
    output logic          done,
    output logic          fail
);
    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          bad;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_SETUP;
                    st_d.cnt   = CW'(relax);
                    st_d.bad   = (strobe == '0);
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_STROBE;
                    st_d.cnt   = CW'(strobe);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_HOLD;
                    st_d.cnt   = CW'(relax);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_IDLE;
                    done       = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, bad: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.phase != PH_IDLE);
    assign fail = st_q.bad;

    // R5
    end_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (st_q.phase == PH_IDLE));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && !start) |=> (st_q.phase == PH_IDLE));
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
    import fuse_rd_pkg::*;
#(
    parameter int WORDS = 128,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        tp_load,
    input  logic [6:0]  tp_addr,
    input  logic [31:0] tp_data
);
    typedef struct packed {
        logic [AW-1:0]    ctl_addr;
        logic             ctl_err;
        logic             ctl_reload;
        logic [KEY_W-1:0] ctl_key;
        logic [PRG_W-1:0] tim_prog;
        logic [RLX_W-1:0] tim_relax;
        logic [STB_W-1:0] tim_rstrb;
        logic [BUS_W-1:0] pgm;
        logic [BUS_W-1:0] result;
    } regs_t;

    regs_t r_d, r_q;

    logic             busy, seq_done, seq_fail, start;
    logic [BUS_W-1:0] fuse_word, ctrl_view, ctrl_new;
    logic             ctrl_hit, cmd_hit;

    fuse_array #(.WORDS(WORDS), .DW(BUS_W)) u_array (
        .clk       (clk),
        .load_en   (tp_load),
        .load_addr (AW'(tp_addr)),
        .load_data (tp_data),
        .rd_addr   (r_q.ctl_addr),
        .rd_data   (fuse_word)
    );

    fuse_seq #(.RW(RLX_W), .SW(STB_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .relax  (r_q.tim_relax),
        .strobe (r_q.tim_rstrb),
        .busy   (busy),
        .done   (seq_done),
        .fail   (seq_fail)
    );

    always_comb begin
        ctrl_view = '0;
        ctrl_view[31:KEY_LSB]  = r_q.ctl_key;
        ctrl_view[BIT_RELOAD]  = r_q.ctl_reload;
        ctrl_view[BIT_ERR]     = r_q.ctl_err;
        ctrl_view[BIT_BUSY]    = busy;
        ctrl_view[6:0]         = 7'(r_q.ctl_addr);
    end

    assign cmd_hit  = bus_wr && (bus_addr == OFS_CMD) && bus_wdata[0];
    assign start    = cmd_hit && !busy;
    assign ctrl_hit = bus_wr && (bus_addr == OFS_CTRL || bus_addr == OFS_SET ||
                                 bus_addr == OFS_CLR);

    always_comb begin
        unique case (bus_addr)
            OFS_SET: ctrl_new = ctrl_view | bus_wdata;
            OFS_CLR: ctrl_new = ctrl_view & ~bus_wdata;
            default: ctrl_new = bus_wdata;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (ctrl_hit) begin
            r_d.ctl_key    = ctrl_new[31:KEY_LSB];
            r_d.ctl_reload = ctrl_new[BIT_RELOAD];
            r_d.ctl_err    = ctrl_new[BIT_ERR];
            if (!busy) begin
                r_d.ctl_addr = ctrl_new[AW-1:0];
            end
        end
        if (bus_wr && bus_addr == OFS_TIMING && !busy) begin
            r_d.tim_prog  = bus_wdata[PRG_W-1:0];
            r_d.tim_relax = bus_wdata[15:12];
            r_d.tim_rstrb = bus_wdata[21:16];
        end
        if (bus_wr && bus_addr == OFS_PGM) begin
            r_d.pgm = bus_wdata;
        end
        if (cmd_hit && busy) begin
            r_d.ctl_err = 1'b1;
        end
        // completion is applied last so a failing read wins over a clear
        if (seq_done) begin
            r_d.result = seq_fail ? POISON_WORD : fuse_word;
            if (seq_fail) begin
                r_d.ctl_err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                OFS_CTRL, OFS_SET, OFS_CLR: bus_rdata = ctrl_view;
                OFS_TIMING: bus_rdata = {10'b0, r_q.tim_rstrb, r_q.tim_relax, r_q.tim_prog};
                OFS_PGM:    bus_rdata = r_q.pgm;
                OFS_RESULT: bus_rdata = r_q.result;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R7
    busy_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && busy) |=> r_q.ctl_err);

    // R6
    poison_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && seq_fail) |=> (r_q.result == POISON_WORD));

    // R10
    done_err_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && seq_fail && ctrl_hit) |=> r_q.ctl_err);

    // R9
    busy_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({r_q.tim_relax, r_q.tim_rstrb, r_q.tim_prog, r_q.ctl_addr}));
endmodule

// File: tb/fuse_rd_ctrl_bench.sv
`timescale 1ns/1ps
module fuse_rd_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tp_load = 1'b0;
    logic [6:0]  tp_addr = '0;
    logic [31:0] tp_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    fuse_rd_ctrl u_fuse_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tp_load(tp_load), .tp_addr(tp_addr), .tp_data(tp_data)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // monitor: compares each read against the item the driver queued
    always @(negedge clk) begin
        if (bus_rd && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks = n_checks + 1;
            if (bus_rdata !== e) begin
                n_fail = n_fail + 1;
                $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic load(input logic [6:0] a, input logic [31:0] d);
        tp_load = 1'b1; tp_addr = a; tp_data = d;
        @(posedge clk); #1;
        tp_load = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1 reset values
        rd(8'h00, 32'h0, "R1 ctrl");
        rd(8'h10, 32'h0, "R1 timing");
        rd(8'h40, 32'h0, "R1 result");
        // R12 preload
        load(7'h05, 32'hCAFE_0005);
        load(7'h7F, 32'h1234_5678);
        // R2 control layout, R8 busy bit not writable
        wr(8'h00, 32'h3E77_0605);
        rd(8'h00, 32'h3E77_0605, "R2 ctrl fields");
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'hFFFF_067F, "R2 R8 reserved and busy bits");
        // R3 aliases
        wr(8'h08, 32'hFFFF_027A);
        rd(8'h00, 32'h0000_0405, "R3 clear alias");
        wr(8'h04, 32'h0000_0102);
        rd(8'h04, 32'h0000_0407, "R3 R8 set alias");
        wr(8'h08, 32'h0000_0100);
        rd(8'h00, 32'h0000_0407, "R8 clear alias on busy");
        // R4 timing layout
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h003F_FFFF, "R4 timing width");
        wr(8'h10, 32'h0002_1ABC);
        rd(8'h10, 32'h0002_1ABC, "R4 timing fields");
        // R5 relax 1, strobe 2: busy 7 cycles
        wr(8'h00, 32'h0000_0005);
        wr(8'h30, 32'h1);
        for (int k = 0; k < 7; k++) rd(8'h00, 32'h0000_0105, "R5 busy window");
        rd(8'h00, 32'h0000_0005, "R5 busy fall");
        rd(8'h40, 32'hCAFE_0005, "R5 R12 fuse word");
        // R11 bit 0 clear
        wr(8'h30, 32'h2);
        rd(8'h00, 32'h0000_0005, "R11 no start");
        // R7 command while busy: relax 0, strobe 1 -> 4 cycles
        wr(8'h10, 32'h0001_0000);
        wr(8'h00, 32'h0000_007F);
        wr(8'h30, 32'h1);
        wr(8'h30, 32'h1);
        for (int k = 0; k < 3; k++) rd(8'h00, 32'h0000_037F, "R7 err while busy");
        rd(8'h00, 32'h0000_027F, "R7 length kept");
        rd(8'h40, 32'h1234_5678, "R7 result kept");
        wr(8'h08, 32'h0000_0200);
        // R9 writes while busy: relax 1, strobe 1 -> 6 cycles
        wr(8'h10, 32'h0001_1000);
        wr(8'h00, 32'h0000_0005);
        wr(8'h30, 32'h1);
        wr(8'h10, 32'h003F_F000);
        wr(8'h00, 32'h0000_0010);
        wr(8'h04, 32'h0000_007F);
        for (int k = 0; k < 3; k++) rd(8'h00, 32'h0000_0105, "R9 addr held");
        rd(8'h00, 32'h0000_0005, "R9 length");
        rd(8'h40, 32'hCAFE_0005, "R9 result addr");
        rd(8'h10, 32'h0001_1000, "R9 timing held");
        // R6 R10 zero strobe with clear on completion edge: 3 cycles
        wr(8'h10, 32'h0000_0000);
        wr(8'h04, 32'h0000_0200);
        wr(8'h30, 32'h1);
        wr(8'h08, 32'h0000_0200);
        rd(8'h00, 32'h0000_0105, "R10 cleared mid read");
        wr(8'h08, 32'h0000_0200);
        rd(8'h00, 32'h0000_0205, "R10 R6 err wins");
        rd(8'h40, 32'hBADA_BADA, "R6 poison");
        // R1 fuse contents survive reset
        do_reset();
        rd(8'h00, 32'h0, "R1 ctrl after reset");
        rd(8'h40, 32'h0, "R1 result after reset");
        wr(8'h10, 32'h0001_0000);
        wr(8'h00, 32'h0000_0005);
        wr(8'h30, 32'h1);
        for (int k = 0; k < 4; k++) rd(8'h00, 32'h0000_0105, "R1 busy");
        rd(8'h40, 32'hCAFE_0005, "R1 array kept");
        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule